// File: doc/BRIEF.md
# Hashed Set-Index Generator for Large Caches

This block turns a byte address into the set number of a set-associative cache. The set is not a fixed slice of the address. It is a seeded hash of every line-address bit, meaning every tag bit and every index bit. Which lines conflict therefore depends on the seed held in the block and not on where software places its objects. A different seed gives a new, independent cache layout. No rule ties the lines of one memory page to distinct sets, so the block fits caches whose way size is larger than a page, such as a second-level cache with 2048 sets.

The hash works in three steps. The line address is padded to a whole number of set-width chunks and XORed with a mask taken from the seed. Each chunk is then joined with its neighbour into a double-width window. Each window is rotated by an amount read from its own seed field, and the low half of the rotated window is kept. The kept halves are XOR-folded into the set number.

A new seed is accepted only on a load strobe and is kept in a register. A bypass input selects plain modulo placement, which forwards the raw index bits. The set output is registered.

Top module: `hrp_set_index`

## Requirements
- R1: While reset is asserted, and after it until the first lookup completes, `set_o` is 0. The held seed also resets to 0.
- R2: The set for the inputs sampled at one rising edge appears on `set_o` right after that edge and stays until the next edge. The latency is exactly one cycle.
- R3: With `bypass_i` high, `set_o` equals `addr_i[OFF_W +: SET_W]` (modulo placement).
- R4: The offset bits `addr_i[OFF_W-1:0]` never change the set chosen in hashed mode.
- R5: In hashed mode, the same line address `addr_i[ADDR_W-1:OFF_W]` under the same held seed always gives the same set.
- R6: `seed_i` has no effect while `seed_load_i` is low. The held seed is unchanged.
- R7: A seed presented with `seed_load_i` high is captured at that edge. A lookup sampled at that same edge still uses the previous seed. Lookups from the next edge on use the new seed.
- R8: One line address is mapped to more than one set across different seeds.
- R9: Two line addresses that differ in one or two bits, whether tag or index bits, share a set under some seeds and are placed apart under others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Byte address of the lookup |
| seed_i | input | SEED_W = NCH*(SET_W+ROT_W) | Candidate seed (XOR mask and rotation fields) |
| seed_load_i | input | 1 | Captures `seed_i` into the seed register |
| bypass_i | input | 1 | Selects modulo placement instead of the hash |
| set_o | output | SET_W | Registered set index for the cache decoders |

## Verification
Every result is due one cycle after its stimulus. The set for an address sampled at edge n is read at the falling edge after edge n. A seed loaded at edge n first affects the lookup sampled at edge n+1.

The bench drives one lookup per cycle and reads the output at the following falling edge. It tracks the held seed itself, applying a load only after the lookup of the same cycle has been scored. Bypass results are compared with the exact index field. Hashed results are compared with the first value seen for the same seed and line. The randomness properties are judged by counting distinct sets and collisions over many seeds.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    // Rounded-up integer division, used to size the chunk array.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/hrp_seed_reg.sv
module hrp_seed_reg #(
    parameter int SEED_W = 48
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [SEED_W-1:0] seed_i,
    output logic [SEED_W-1:0] seed_o
);
    typedef struct packed {
        logic [SEED_W-1:0] seed;
    } seed_state_t;

    seed_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.seed = seed_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seed_o = st_q.seed;

    // R6: without the strobe the held seed does not move
    assert_seed_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(seed_o));

    // R7: with the strobe the presented seed is held from the next cycle
    assert_seed_take_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (seed_o == $past(seed_i)));

endmodule

// File: rtl/hrp_window_rot.sv
// Rotates a double-width window right by amt mod 2*W and keeps the low W bits.
module hrp_window_rot #(
    parameter int W     = 11,
    parameter int AMT_W = $clog2(2 * W)
) (
    input  logic [2*W-1:0]   win_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [W-1:0]     win_o
);
    localparam int SPAN = 2 * W;

    always_comb begin
        int shift;
        int pos;
        shift = int'(amt_i);
        if (shift >= SPAN) begin
            shift = shift - SPAN;
        end
        for (int k = 0; k < W; k++) begin
            pos = k + shift;
            if (pos >= SPAN) begin
                pos = pos - SPAN;
            end
            win_o[k] = win_i[pos];
        end
    end

endmodule

// File: rtl/hrp_hash_core.sv
module hrp_hash_core import hrp_pkg::*; #(
    parameter  int LA_W   = 26,
    parameter  int SET_W  = 11,
    localparam int NCH    = ceil_div(LA_W, SET_W),
    localparam int ROT_W  = $clog2(2 * SET_W),
    localparam int MIX_W  = NCH * SET_W,
    localparam int SEED_W = MIX_W + NCH * ROT_W
) (
    input  logic [LA_W-1:0]   line_i,
    input  logic [SEED_W-1:0] seed_i,
    output logic [SET_W-1:0]  set_o
);
    logic [MIX_W-1:0] padded;
    logic [MIX_W-1:0] mixed;
    logic [SET_W-1:0] part [NCH];

    always_comb begin
        padded = '0;
        padded[LA_W-1:0] = line_i;
    end

    // Seed mask first: every bit of the line is whitened before mixing.
    assign mixed = padded ^ seed_i[MIX_W-1:0];

    // One lane per chunk: window = {next chunk, own chunk}, rotated by a seed field.
    for (genvar g = 0; g < NCH; g++) begin : g_lane
        localparam int NXT = (g + 1) % NCH;
        hrp_window_rot #(
            .W    (SET_W),
            .AMT_W(ROT_W)
        ) u_rot (
            .win_i({mixed[NXT*SET_W +: SET_W], mixed[g*SET_W +: SET_W]}),
            .amt_i(seed_i[MIX_W + g*ROT_W +: ROT_W]),
            .win_o(part[g])
        );
    end

    always_comb begin
        set_o = '0;
        for (int i = 0; i < NCH; i++) begin
            set_o = set_o ^ part[i];
        end
    end

endmodule

// File: rtl/hrp_set_index.sv
module hrp_set_index import hrp_pkg::*; #(
    parameter  int ADDR_W = 32,
    parameter  int OFF_W  = 6,
    parameter  int SET_W  = 11,
    localparam int LA_W   = ADDR_W - OFF_W,
    localparam int NCH    = ceil_div(LA_W, SET_W),
    localparam int ROT_W  = $clog2(2 * SET_W),
    localparam int SEED_W = NCH * (SET_W + ROT_W)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SEED_W-1:0] seed_i,
    input  logic              seed_load_i,
    input  logic              bypass_i,
    output logic [SET_W-1:0]  set_o
);
    typedef struct packed {
        logic [SET_W-1:0] set;
    } idx_state_t;

    idx_state_t        st_d, st_q;
    logic [SEED_W-1:0] seed_q;
    logic [SET_W-1:0]  hashed;
    logic              offset_unused;

    assign offset_unused = ^addr_i[OFF_W-1:0];

    hrp_seed_reg #(
        .SEED_W(SEED_W)
    ) u_seed (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .load_i(seed_load_i),
        .seed_i(seed_i),
        .seed_o(seed_q)
    );

    hrp_hash_core #(
        .LA_W (LA_W),
        .SET_W(SET_W)
    ) u_hash (
        .line_i(addr_i[ADDR_W-1:OFF_W]),
        .seed_i(seed_q),
        .set_o (hashed)
    );

    always_comb begin
        st_d = st_q;
        if (bypass_i) begin
            st_d.set = addr_i[OFF_W +: SET_W];
        end else begin
            st_d.set = hashed;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign set_o = st_q.set;

    // R3: bypass gives modulo placement one cycle later
    assert_bypass_modulo_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        bypass_i |=> (set_o == $past(addr_i[OFF_W +: SET_W])));

    // R5: same line, unchanged seed, hashed mode twice in a row -> same set
    assert_same_line_same_set_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(seed_load_i) && !bypass_i && !$past(bypass_i) &&
         (addr_i[ADDR_W-1:OFF_W] == $past(addr_i[ADDR_W-1:OFF_W])))
        |=> $stable(set_o));

endmodule

// File: tb/hrp_set_index_test.sv
module hrp_set_index_test;
    localparam int ADDR_W = 16;
    localparam int OFF_W  = 4;
    localparam int SET_W  = 4;
    localparam int LA_W   = ADDR_W - OFF_W;
    localparam int SEED_W = 21;    // 3 chunks * (4 mask bits + 3 rotation bits)

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] addr;
    logic [SEED_W-1:0] seed;
    logic              ld;
    logic              byp;
    logic [SET_W-1:0]  set_o;

    int checks = 0;
    int fails  = 0;

    logic [SEED_W-1:0] model_seed;
    logic [SET_W-1:0]  memo [longint];

    always #2 clk = ~clk;   // 250 MHz

    hrp_set_index #(
        .ADDR_W(ADDR_W),
        .OFF_W (OFF_W),
        .SET_W (SET_W)
    ) uut (
        .clk_i      (clk),
        .rst_i      (rst),
        .addr_i     (addr),
        .seed_i     (seed),
        .seed_load_i(ld),
        .bypass_i   (byp),
        .set_o      (set_o)
    );

    task automatic note(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Called at a falling edge: drive, let one rising edge pass, read at next falling edge.
    task automatic lookup(input logic [ADDR_W-1:0] a, input bit b, input bit l,
                          input logic [SEED_W-1:0] s, input string tag,
                          output logic [SET_W-1:0] got);
        logic [SEED_W-1:0] used;
        longint key;
        addr = a; byp = b; ld = l; seed = s;
        used = model_seed;
        if (l) model_seed = s;
        @(negedge clk);
        got = set_o;
        if (b) begin
            note(got == a[OFF_W +: SET_W], tag, int'(got), int'(a[OFF_W +: SET_W]));
        end else begin
            key = longint'({used, a[ADDR_W-1:OFF_W]});
            if (memo.exists(key)) note(got == memo[key], tag, int'(got), int'(memo[key]));
            else memo[key] = got;
        end
    endtask

    task automatic load_seed(input logic [SEED_W-1:0] s);
        logic [SET_W-1:0] dummy;
        lookup(ADDR_W'($urandom), 1'b1, 1'b1, s, "R3 bypass during load", dummy);
    endtask

    function automatic logic [SEED_W-1:0] rnd_seed();
        return SEED_W'($urandom);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [SET_W-1:0]  got, got_b;
        logic [ADDR_W-1:0] a;
        logic [SEED_W-1:0] s1, s2;
        rst = 1'b1; addr = '0; seed = '0; ld = 1'b0; byp = 1'b0;
        model_seed = '0;
        repeat (3) @(negedge clk);
        note(set_o == '0, "R1 set during reset", int'(set_o), 0);
        rst = 1'b0;
        @(negedge clk);
        note(set_o == '0, "R1 set after reset", int'(set_o), 0);

        // R3 / R2: modulo placement, one cycle latency
        for (int i = 0; i < 24; i++) begin
            lookup(ADDR_W'($urandom), 1'b1, 1'b0, '0, "R3 R2 bypass modulo", got);
        end

        // R4 / R5: offsets ignored, repeated lines consistent
        s1 = rnd_seed();
        load_seed(s1);
        for (int i = 0; i < 30; i++) begin
            a = ADDR_W'($urandom);
            lookup(a, 1'b0, 1'b0, '0, "R5 first lookup", got);
            a[OFF_W-1:0] = OFF_W'($urandom);
            lookup(a, 1'b0, 1'b0, '0, "R4 offset change", got);
            lookup(a, 1'b0, 1'b0, '0, "R5 repeat lookup", got);
        end

        // R6: seed input without strobe is ignored
        a = ADDR_W'($urandom);
        lookup(a, 1'b0, 1'b0, '0, "R5 prime", got);
        for (int i = 0; i < 10; i++) begin
            lookup(a, 1'b0, 1'b0, rnd_seed(), "R6 seed without strobe", got);
        end

        // R7: lookup at the load edge still uses the old seed
        s2 = rnd_seed();
        lookup(a, 1'b0, 1'b1, s2, "R7 lookup at load edge", got);
        lookup(a, 1'b0, 1'b0, '0, "R7 first lookup under new seed", got);
        lookup(a, 1'b0, 1'b0, '0, "R7 repeat under new seed", got);

        // R8: one line reaches several sets across seeds
        for (int i = 0; i < 10; i++) begin
            logic [(1<<SET_W)-1:0] seen;
            a = ADDR_W'($urandom);
            seen = '0;
            for (int k = 0; k < 32; k++) begin
                load_seed(rnd_seed());
                lookup(a, 1'b0, 1'b0, '0, "R5 sweep", got);
                seen[got] = 1'b1;
            end
            note($countones(seen) >= 2, "R8 distinct sets over seeds", $countones(seen), 2);
        end

        // R9: pairs differing in one or two line bits collide only sometimes
        for (int p = 0; p < 16; p++) begin
            logic [ADDR_W-1:0] b;
            int j1, j2, col;
            a  = ADDR_W'($urandom);
            j1 = $urandom_range(0, LA_W - 1);
            b  = a ^ (ADDR_W'(1) << (OFF_W + j1));
            if (p % 2 == 1) begin
                j2 = (j1 + 1 + $urandom_range(0, LA_W - 2)) % LA_W;
                b  = b ^ (ADDR_W'(1) << (OFF_W + j2));
            end
            b[OFF_W-1:0] = OFF_W'($urandom);
            col = 0;
            for (int k = 0; k < 160; k++) begin
                load_seed(rnd_seed());
                lookup(a, 1'b0, 1'b0, '0, "R5 pair A", got);
                lookup(b, 1'b0, 1'b0, '0, "R5 pair B", got_b);
                if (got == got_b) col++;
            end
            note(col > 0,   "R9 pair collides under some seed", col, 1);
            note(col < 160, "R9 pair separates under some seed", col, 159);
        end

        summary();
        $finish;
    end

endmodule